// File: doc/BRIEF.md
# Signature Accelerator Register Controller

This block is the memory-mapped control front end of a hardware signature engine. Software fills parameter buffers (Y, M, RB, a 48-byte box and X) and four IV words with 32-bit writes. It then issues commands by writing bit 0 of three command offsets. The block sequences the external engines through start/done handshakes: a key-derivation engine, a block-decrypt engine, a digest engine that reports whether its result matched, and a modular-exponentiation engine. Software reads the status registers and the Z result buffer.

The engines reach the buffers through a shared engine write port and a shared engine read port. Each port names a buffer with a 3-bit selector. The decrypt engine writes the plaintext back in place. The controller then checks the padding bytes of the decrypted box and asks the digest engine for a comparison. The exponentiation step is started only when the digest matched.

A two-bit check status reports the outcome. It starts with both failure bits set. Each bit is cleared only when its own check passes. A finish command wipes every buffer, the IV and the derived key.

Top module: `sig_accel_regctl`

## Requirements
- R1: After reset, busy reads 0, the check register at 0xE14 reads 3, the derived key and IV outputs are all zero, and no start output is high.
- R2: A word write lands in its buffer at word index (offset − base)/4. The bases and sizes are: Y at 0x000 (96 words), M at 0x200 (96), RB at 0x400 (96), box at 0x600 (12), X at 0x800 (96). It is visible on the engine read port, which uses selector 0=Y, 1=M, 2=RB, 3=box, 4=X, 5=Z.
- R3: Writes to 0x630, 0x634, 0x638 and 0x63C set IV words 0..3, and IV word i drives bits 32i+31..32i of `iv_out`.
- R4: An engine write to selector 5 (Z) at word i can be read back over the bus at 0xA00 + 4i, one cycle after the read request. Bus writes to the Z region are ignored.
- R5: Status reads are as follows. Busy at 0xE0C is in bit 0. Key-wrong at 0xE10 reads 0. Check at 0xE14 is in bits 1:0. Date at 0xE20 reads 0x20200618. Parameter buffers, IV, command offsets and unmapped offsets read 0.
- R6: A write of bit 0 = 1 to 0xE00 pulses `kdf_start` for one cycle and holds busy until `kdf_done`. At `kdf_done`, `kdf_key` is captured onto `key_out`.
- R7: A write of bit 0 = 1 to 0xE04 sets the check register to 3 and pulses `dec_start`. At `dec_done`, bit 1 (bad padding) is cleared if and only if box words 10 and 11 both equal 0x08080808. `hash_start` then pulses.
- R8: At `hash_done`, if `hash_match` is 1, check bit 0 (digest error) is cleared and `exp_start` pulses, and busy holds until `exp_done`. If `hash_match` is 0, `exp_start` never pulses and busy drops.
- R9: A write of bit 0 = 1 to 0xE08 clears all six buffers, the IV and the derived key to zero and leaves the check register unchanged.
- R10: While busy reads 1, command writes and bus writes to buffers or IV have no effect.
- R11: Accesses with a byte enable other than 4'hF, or with address bits 1:0 nonzero, are ignored: writes change nothing and reads return 0. Writes to read-only or unmapped offsets change nothing.
- R12: A command write with bit 0 = 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_be | input | 4 | Byte enables; only 4'hF is a legal access |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| kdf_start | output | 1 | Key-derivation start pulse |
| kdf_done | input | 1 | Key derivation finished |
| kdf_key | input | 256 | Derived key from the key engine |
| key_out | output | 256 | Stored derived key |
| iv_out | output | 128 | IV words, word 0 in the low bits |
| dec_start | output | 1 | Decrypt start pulse |
| dec_done | input | 1 | Decrypt finished, plaintext written back |
| hash_start | output | 1 | Digest start pulse |
| hash_done | input | 1 | Digest finished |
| hash_match | input | 1 | Digest equals the stored digest (valid with hash_done) |
| exp_start | output | 1 | Exponentiation start pulse |
| exp_done | input | 1 | Exponentiation finished |
| eng_wr_en | input | 1 | Engine buffer write |
| eng_wr_sel | input | 3 | Engine write buffer selector |
| eng_wr_idx | input | 7 | Engine write word index |
| eng_wr_data | input | 32 | Engine write data |
| eng_rd_sel | input | 3 | Engine read buffer selector |
| eng_rd_idx | input | 7 | Engine read word index |
| eng_rd_data | output | 32 | Engine read data (combinational) |

## Verification
The assertions take some things for granted about the engines. Each engine raises its done input only while its own phase is running. `hash_match` is meaningful only together with `hash_done`. The decrypt engine finishes its box write-back at least one cycle before `dec_done`. The bench's engine models keep to these rules: they drive each done input for exactly one cycle, only after the matching start pulse has been seen, and they finish engine writes before the done pulse. Bus requests are held for one cycle each and never overlap engine writes to the same word.

// File: rtl/sig_accel_pkg.sv
package sig_accel_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 12;
  localparam int BIG_WORDS = 96;
  localparam int BOX_WORDS = 12;
  localparam int IV_WORDS  = 4;
  localparam int KEY_W     = 256;
  localparam int NUM_BUFS  = 6;
  localparam int IDX_W     = $clog2(BIG_WORDS);
  localparam int PAD_IDX   = 10;
  localparam logic [WORD_W-1:0] DATE_CODE = 32'h2020_0618;
  localparam logic [WORD_W-1:0] PAD_WORD  = 32'h0808_0808;
  localparam logic [1:0] CHECK_INIT = 2'b11;

  typedef enum logic [2:0] {
    SEL_Y = 3'd0, SEL_M = 3'd1, SEL_RB = 3'd2,
    SEL_BOX = 3'd3, SEL_X = 3'd4, SEL_Z = 3'd5
  } buf_sel_e;

  typedef enum logic [3:0] {
    RG_NONE, RG_BUF, RG_ZBUF, RG_IV, RG_CMD_KEY, RG_CMD_CALC,
    RG_CMD_FIN, RG_BUSY, RG_KEYWRONG, RG_CHECK, RG_DATE
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    buf_sel_e         sel;
    logic [IDX_W-1:0] idx;
  } decode_t;

  function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
    decode_t d;
    logic [IDX_W-1:0] wi;
    wi     = a[8:2];
    d.kind = RG_NONE;
    d.sel  = SEL_Y;
    d.idx  = wi;
    case (a[11:9])
      3'd0: if (int'(wi) < BIG_WORDS) begin d.kind = RG_BUF; d.sel = SEL_Y;  end
      3'd1: if (int'(wi) < BIG_WORDS) begin d.kind = RG_BUF; d.sel = SEL_M;  end
      3'd2: if (int'(wi) < BIG_WORDS) begin d.kind = RG_BUF; d.sel = SEL_RB; end
      3'd4: if (int'(wi) < BIG_WORDS) begin d.kind = RG_BUF; d.sel = SEL_X;  end
      3'd5: if (int'(wi) < BIG_WORDS) begin d.kind = RG_ZBUF; d.sel = SEL_Z; end
      3'd3: begin
        if (int'(wi) < BOX_WORDS) begin
          d.kind = RG_BUF;
          d.sel  = SEL_BOX;
        end else if (int'(wi) < BOX_WORDS + IV_WORDS) begin
          d.kind = RG_IV;
          d.idx  = wi - IDX_W'(BOX_WORDS);
        end
      end
      3'd7: begin
        case (a[8:0])
          9'h000: d.kind = RG_CMD_KEY;
          9'h004: d.kind = RG_CMD_CALC;
          9'h008: d.kind = RG_CMD_FIN;
          9'h00C: d.kind = RG_BUSY;
          9'h010: d.kind = RG_KEYWRONG;
          9'h014: d.kind = RG_CHECK;
          9'h020: d.kind = RG_DATE;
          default: d.kind = RG_NONE;
        endcase
      end
      default: d.kind = RG_NONE;
    endcase
    return d;
  endfunction

  function automatic logic pad_ok(input logic [WORD_W-1:0] w0, input logic [WORD_W-1:0] w1);
    return (w0 == PAD_WORD) && (w1 == PAD_WORD);
  endfunction

  function automatic logic word_access(input logic [3:0] be, input logic [1:0] lo);
    return (be == 4'hF) && (lo == 2'b00);
  endfunction
endpackage

// File: rtl/sig_wordbuf.sv
module sig_wordbuf
  import sig_accel_pkg::*;
#(
  parameter int WORDS   = BIG_WORDS,
  parameter int TAP_IDX = PAD_IDX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bw_en,
  input  logic [IDX_W-1:0]  bw_idx,
  input  logic [WORD_W-1:0] bw_data,
  input  logic              ew_en,
  input  logic [IDX_W-1:0]  ew_idx,
  input  logic [WORD_W-1:0] ew_data,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic [WORD_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic [WORD_W-1:0] rb_data,
  output logic [WORD_W-1:0] tap0,
  output logic [WORD_W-1:0] tap1
);
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [WORD_W-1:0] mem [WORDS];

  wire bw_hit = bw_en && (int'(bw_idx) < WORDS);
  wire ew_hit = ew_en && (int'(ew_idx) < WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (ew_hit) mem[ew_idx[AW-1:0]] <= ew_data;
      if (bw_hit) mem[bw_idx[AW-1:0]] <= bw_data;
    end
  end

  assign ra_data = (int'(ra_idx) < WORDS) ? mem[ra_idx[AW-1:0]] : '0;
  assign rb_data = (int'(rb_idx) < WORDS) ? mem[rb_idx[AW-1:0]] : '0;
  assign tap0    = mem[TAP_IDX];
  assign tap1    = mem[TAP_IDX + 1];
endmodule

// File: rtl/sig_seq.sv
module sig_seq
  import sig_accel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_key,
  input  logic       cmd_calc,
  input  logic       pad_good,
  input  logic       kdf_done,
  input  logic       dec_done,
  input  logic       hash_done,
  input  logic       hash_match,
  input  logic       exp_done,
  output logic       busy,
  output logic       accept_key,
  output logic       accept_calc,
  output logic       key_load,
  output logic       kdf_start,
  output logic       dec_start,
  output logic       hash_start,
  output logic       exp_start,
  output logic [1:0] check
);
  typedef enum logic [2:0] {S_IDLE, S_KEY, S_DEC, S_HASH, S_EXP} state_e;
  state_e state;

  assign busy        = (state != S_IDLE);
  assign accept_key  = cmd_key  && (state == S_IDLE);
  assign accept_calc = cmd_calc && (state == S_IDLE) && !cmd_key;
  assign key_load    = (state == S_KEY) && kdf_done;

  wire dec_fin  = (state == S_DEC)  && dec_done;
  wire hash_fin = (state == S_HASH) && hash_done;
  wire exp_fin  = (state == S_EXP)  && exp_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      check      <= CHECK_INIT;
      kdf_start  <= 1'b0;
      dec_start  <= 1'b0;
      hash_start <= 1'b0;
      exp_start  <= 1'b0;
    end else begin
      kdf_start  <= 1'b0;
      dec_start  <= 1'b0;
      hash_start <= 1'b0;
      exp_start  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept_key) begin
            state     <= S_KEY;
            kdf_start <= 1'b1;
          end else if (accept_calc) begin
            state     <= S_DEC;
            dec_start <= 1'b1;
            check     <= CHECK_INIT;
          end
        end
        S_KEY: if (key_load) state <= S_IDLE;
        S_DEC: begin
          if (dec_fin) begin
            if (pad_good) check[1] <= 1'b0;
            state      <= S_HASH;
            hash_start <= 1'b1;
          end
        end
        S_HASH: begin
          if (hash_fin) begin
            if (hash_match) begin
              check[0]  <= 1'b0;
              exp_start <= 1'b1;
              state     <= S_EXP;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_EXP: if (exp_fin) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sig_accel_regctl.sv
module sig_accel_regctl
  import sig_accel_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [3:0]           req_be,
  input  logic [WORD_W-1:0]    req_wdata,
  output logic                 rd_valid,
  output logic [WORD_W-1:0]    rd_data,
  output logic                 kdf_start,
  input  logic                 kdf_done,
  input  logic [KEY_W-1:0]     kdf_key,
  output logic [KEY_W-1:0]     key_out,
  output logic [IV_WORDS*WORD_W-1:0] iv_out,
  output logic                 dec_start,
  input  logic                 dec_done,
  output logic                 hash_start,
  input  logic                 hash_done,
  input  logic                 hash_match,
  output logic                 exp_start,
  input  logic                 exp_done,
  input  logic                 eng_wr_en,
  input  logic [2:0]           eng_wr_sel,
  input  logic [IDX_W-1:0]     eng_wr_idx,
  input  logic [WORD_W-1:0]    eng_wr_data,
  input  logic [2:0]           eng_rd_sel,
  input  logic [IDX_W-1:0]     eng_rd_idx,
  output logic [WORD_W-1:0]    eng_rd_data
);
  decode_t dec;
  assign dec = decode_addr(req_addr);

  wire legal  = word_access(req_be, req_addr[1:0]);
  wire wr_ok  = req_valid && req_write && legal;
  wire rd_req = req_valid && !req_write;

  logic busy_w;
  logic [1:0] check_w;
  logic accept_key, accept_calc, key_load;

  wire buf_wr     = wr_ok && !busy_w && (dec.kind == RG_BUF);
  wire iv_wr      = wr_ok && !busy_w && (dec.kind == RG_IV);
  wire cmd_key_w  = wr_ok && req_wdata[0] && (dec.kind == RG_CMD_KEY);
  wire cmd_calc_w = wr_ok && req_wdata[0] && (dec.kind == RG_CMD_CALC);
  wire fin_fire   = wr_ok && req_wdata[0] && !busy_w && (dec.kind == RG_CMD_FIN);

  logic [WORD_W-1:0] bus_rd [NUM_BUFS];
  logic [WORD_W-1:0] eng_rd [NUM_BUFS];
  logic [WORD_W-1:0] tap0   [NUM_BUFS];
  logic [WORD_W-1:0] tap1   [NUM_BUFS];

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
    localparam int W = (g == int'(SEL_BOX)) ? BOX_WORDS : BIG_WORDS;
    sig_wordbuf #(.WORDS(W), .TAP_IDX(PAD_IDX)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fin_fire),
      .bw_en   (buf_wr && (dec.sel == buf_sel_e'(g))),
      .bw_idx  (dec.idx),
      .bw_data (req_wdata),
      .ew_en   (eng_wr_en && (eng_wr_sel == 3'(g))),
      .ew_idx  (eng_wr_idx),
      .ew_data (eng_wr_data),
      .ra_idx  (dec.idx),
      .ra_data (bus_rd[g]),
      .rb_idx  (eng_rd_idx),
      .rb_data (eng_rd[g]),
      .tap0    (tap0[g]),
      .tap1    (tap1[g])
    );
  end

  wire pad_good = pad_ok(tap0[SEL_BOX], tap1[SEL_BOX]);

  sig_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_key    (cmd_key_w),
    .cmd_calc   (cmd_calc_w),
    .pad_good   (pad_good),
    .kdf_done   (kdf_done),
    .dec_done   (dec_done),
    .hash_done  (hash_done),
    .hash_match (hash_match),
    .exp_done   (exp_done),
    .busy       (busy_w),
    .accept_key (accept_key),
    .accept_calc(accept_calc),
    .key_load   (key_load),
    .kdf_start  (kdf_start),
    .dec_start  (dec_start),
    .hash_start (hash_start),
    .exp_start  (exp_start),
    .check      (check_w)
  );

  logic [WORD_W-1:0] iv_q [IV_WORDS];
  logic [KEY_W-1:0]  key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < IV_WORDS; i++) iv_q[i] <= '0;
      key_q <= '0;
    end else if (fin_fire) begin
      for (int i = 0; i < IV_WORDS; i++) iv_q[i] <= '0;
      key_q <= '0;
    end else begin
      if (iv_wr) iv_q[dec.idx[$clog2(IV_WORDS)-1:0]] <= req_wdata;
      if (key_load) key_q <= kdf_key;
    end
  end

  for (genvar i = 0; i < IV_WORDS; i++) begin : g_iv
    assign iv_out[i*WORD_W +: WORD_W] = iv_q[i];
  end
  assign key_out = key_q;

  always_comb begin
    eng_rd_data = '0;
    for (int g = 0; g < NUM_BUFS; g++)
      if (eng_rd_sel == 3'(g)) eng_rd_data = eng_rd[g];
  end

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    case (dec.kind)
      RG_ZBUF:  rd_mux = bus_rd[SEL_Z];
      RG_BUSY:  rd_mux = {{(WORD_W-1){1'b0}}, busy_w};
      RG_CHECK: rd_mux = {{(WORD_W-2){1'b0}}, check_w};
      RG_DATE:  rd_mux = DATE_CODE;
      default:  rd_mux = '0;
    endcase
    if (!legal) rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/sig_accel_regctl_chk.sv
module sig_accel_regctl_chk
  import sig_accel_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 busy,
  input logic                 kdf_start,
  input logic                 dec_start,
  input logic                 hash_start,
  input logic                 exp_start,
  input logic                 hash_done,
  input logic                 hash_match,
  input logic [1:0]           check,
  input logic                 accept_calc,
  input logic                 fin_fire,
  input logic [KEY_W-1:0]     key_out,
  input logic [IV_WORDS*WORD_W-1:0] iv_out
);
  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kdf_start, dec_start, hash_start, exp_start})); // R7

  AST_KEY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    kdf_start |-> $past(!busy)); // R10

  AST_CALC_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_start |-> $past(!busy)); // R10

  AST_EXP_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    exp_start |-> $past(hash_done && hash_match && busy)); // R8

  AST_CHECK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    accept_calc |=> (check == CHECK_INIT)); // R7

  AST_CHECK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(check[0]) || $rose(check[1])) |-> $past(accept_calc)); // R7

  AST_FINISH_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_fire |=> (key_out == '0 && iv_out == '0)); // R9

  AST_BUSY_WHILE_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    exp_start |-> busy); // R8
endmodule

bind sig_accel_regctl sig_accel_regctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_w),
  .kdf_start  (kdf_start),
  .dec_start  (dec_start),
  .hash_start (hash_start),
  .exp_start  (exp_start),
  .hash_done  (hash_done),
  .hash_match (hash_match),
  .check      (check_w),
  .accept_calc(accept_calc),
  .fin_fire   (fin_fire),
  .key_out    (key_out),
  .iv_out     (iv_out)
);

// File: tb/sig_accel_regctl_tb.sv
module sig_accel_regctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [3:0] req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic kdf_start, dec_start, hash_start, exp_start;
  logic kdf_done = 0, dec_done = 0, hash_done = 0, hash_match = 0, exp_done = 0;
  logic [255:0] kdf_key = '0;
  logic [255:0] key_out;
  logic [127:0] iv_out;
  logic eng_wr_en = 0;
  logic [2:0] eng_wr_sel = '0, eng_rd_sel = '0;
  logic [6:0] eng_wr_idx = '0, eng_rd_idx = '0;
  logic [31:0] eng_wr_data = '0;
  logic [31:0] eng_rd_data;

  int checks = 0;
  int errors = 0;

  sig_accel_regctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .kdf_start(kdf_start),
    .kdf_done(kdf_done), .kdf_key(kdf_key), .key_out(key_out), .iv_out(iv_out),
    .dec_start(dec_start), .dec_done(dec_done), .hash_start(hash_start),
    .hash_done(hash_done), .hash_match(hash_match), .exp_start(exp_start),
    .exp_done(exp_done), .eng_wr_en(eng_wr_en), .eng_wr_sel(eng_wr_sel),
    .eng_wr_idx(eng_wr_idx), .eng_wr_data(eng_wr_data), .eng_rd_sel(eng_rd_sel),
    .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_be = 4'hF;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 0; req_be = 4'hF;
    d = rd_data;
  endtask

  task automatic eng_wr(input logic [2:0] s, input logic [6:0] i, input logic [31:0] d);
    @(negedge clk);
    eng_wr_en = 1; eng_wr_sel = s; eng_wr_idx = i; eng_wr_data = d;
    @(negedge clk);
    eng_wr_en = 0;
  endtask

  task automatic eng_rd(input logic [2:0] s, input logic [6:0] i, output logic [31:0] d);
    eng_rd_sel = s; eng_rd_idx = i;
    #1 d = eng_rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 start outputs", {kdf_start, dec_start, hash_start, exp_start}, 0);
    chk("R1 key", key_out, 0);
    chk("R1 iv", iv_out, 0);
    bus_rd(12'hE14, v); chk("R1 check", v, 3);
    bus_rd(12'hE0C, v); chk("R1 busy", v, 0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    bus_rd(12'hE20, v); chk("R5 date", v, 32'h20200618);
    bus_rd(12'hE10, v); chk("R5 key-wrong", v, 0);
    bus_wr(12'h010, 32'hDEAD0001);
    bus_rd(12'h010, v); chk("R5 param read zero", v, 0);
    bus_rd(12'hF00, v); chk("R5 unmapped read", v, 0);
    bus_rd(12'hE00, v); chk("R5 command read", v, 0);
    bus_wr(12'hE20, 32'h0);
    bus_rd(12'hE20, v); chk("R11 date write ignored", v, 32'h20200618);
  endtask

  task automatic t_buffers();
    logic [31:0] v;
    bus_wr(12'h000, 32'h1111_0000);
    bus_wr(12'h37C, 32'h2222_005F);
    bus_wr(12'h414, 32'h3333_0005);
    bus_wr(12'h62C, 32'h4444_000B);
    bus_wr(12'h8C8, 32'h5555_0032);
    eng_rd(0, 0, v);  chk("R2 Y[0]", v, 32'h1111_0000);
    eng_rd(1, 95, v); chk("R2 M[95]", v, 32'h2222_005F);
    eng_rd(2, 5, v);  chk("R2 RB[5]", v, 32'h3333_0005);
    eng_rd(3, 11, v); chk("R2 box[11]", v, 32'h4444_000B);
    eng_rd(4, 50, v); chk("R2 X[50]", v, 32'h5555_0032);
    eng_rd(0, 95, v); chk("R2 Y[95] untouched", v, 0);
  endtask

  task automatic t_iv();
    bus_wr(12'h630, 32'hA0A0_0000);
    bus_wr(12'h634, 32'hA1A1_0001);
    bus_wr(12'h638, 32'hA2A2_0002);
    bus_wr(12'h63C, 32'hA3A3_0003);
    chk("R3 iv", iv_out, {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000});
  endtask

  task automatic t_z();
    logic [31:0] v;
    eng_wr(5, 3, 32'hC0DE_0003);
    bus_rd(12'hA0C, v); chk("R4 Z[3] read", v, 32'hC0DE_0003);
    bus_wr(12'hA0C, 32'h0BAD_0BAD);
    bus_rd(12'hA0C, v); chk("R4 Z bus write ignored", v, 32'hC0DE_0003);
  endtask

  task automatic t_nonword();
    logic [31:0] v;
    bus_wr(12'h004, 32'h7777_7777, 4'h3);
    eng_rd(0, 1, v); chk("R11 partial write", v, 0);
    bus_wr(12'h005, 32'h8888_8888);
    eng_rd(0, 1, v); chk("R11 misaligned write", v, 0);
    bus_rd(12'hE20, v, 4'h1); chk("R11 partial read", v, 0);
    bus_wr(12'hE00, 32'h1, 4'h1);
    chk("R11 partial command", kdf_start, 0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    bus_wr(12'hE00, 32'h0);
    chk("R12 bit0 clear", kdf_start, 0);
    bus_wr(12'hE00, 32'h1);
    chk("R6 kdf_start pulse", kdf_start, 1);
    @(negedge clk);
    chk("R6 kdf_start one cycle", kdf_start, 0);
    bus_rd(12'hE0C, v); chk("R6 busy", v, 1);
    bus_wr(12'hE04, 32'h1);
    chk("R10 calc ignored", dec_start, 0);
    bus_wr(12'h008, 32'h9999_0002);
    bus_wr(12'h630, 32'h0);
    bus_wr(12'hE08, 32'h1);
    kdf_key = {8{32'h5A5A_1234}};
    @(negedge clk); kdf_done = 1;
    @(negedge clk); kdf_done = 0;
    chk("R6 key captured", key_out, {8{32'h5A5A_1234}});
    bus_rd(12'hE0C, v); chk("R6 busy drops", v, 0);
    eng_rd(0, 2, v); chk("R10 buffer write ignored", v, 0);
    chk("R10 iv/finish ignored", iv_out[31:0], 32'hA0A0_0000);
    chk("R10 no late decrypt", dec_start, 0);
  endtask

  task automatic run_calc(input logic [31:0] p10, input logic [31:0] p11,
                          input logic match, input logic [1:0] exp_chk, input string tag);
    logic [31:0] v;
    bus_wr(12'hE04, 32'h1);
    chk({tag, " R7 dec_start"}, dec_start, 1);
    bus_rd(12'hE14, v); chk({tag, " R7 check armed"}, v, 3);
    eng_wr(3, 10, p10);
    eng_wr(3, 11, p11);
    @(negedge clk); dec_done = 1;
    @(negedge clk); dec_done = 0;
    chk({tag, " R7 hash_start"}, hash_start, 1);
    bus_rd(12'hE14, v); chk({tag, " R7 padding bit"}, v, {30'b0, exp_chk[1], 1'b1});
    @(negedge clk); hash_done = 1; hash_match = match;
    @(negedge clk); hash_done = 0; hash_match = 0;
    chk({tag, " R8 exp_start"}, exp_start, match);
    bus_rd(12'hE0C, v); chk({tag, " R8 busy"}, v, {31'b0, match});
    if (match) begin
      @(negedge clk); exp_done = 1;
      @(negedge clk); exp_done = 0;
      bus_rd(12'hE0C, v); chk({tag, " R8 busy after exp"}, v, 0);
    end
    bus_rd(12'hE14, v); chk({tag, " R8 final check"}, v, {30'b0, exp_chk});
  endtask

  task automatic t_finish();
    logic [31:0] v;
    bus_wr(12'hE08, 32'h1);
    chk("R9 key wiped", key_out, 0);
    chk("R9 iv wiped", iv_out, 0);
    eng_rd(0, 0, v);  chk("R9 Y wiped", v, 0);
    eng_rd(1, 95, v); chk("R9 M wiped", v, 0);
    eng_rd(3, 10, v); chk("R9 box wiped", v, 0);
    eng_rd(4, 50, v); chk("R9 X wiped", v, 0);
    bus_rd(12'hA0C, v); chk("R9 Z wiped", v, 0);
    bus_rd(12'hE14, v); chk("R9 check kept", v, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_status();
    t_buffers();
    t_iv();
    t_z();
    t_nonword();
    t_key();
    run_calc(32'h0808_0808, 32'h0808_0808, 1'b1, 2'b00, "pass");
    run_calc(32'h0808_0808, 32'h0808_0809, 1'b0, 2'b11, "badpad-mdfail");
    run_calc(32'h0808_0808, 32'h0008_0808, 1'b1, 2'b10, "badpad-mdok");
    t_finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule